// File: doc/BRIEF.md
# I2C GPIO Expander Slave

This block is an I2C target that runs an eight-pin bidirectional port through four byte registers. SCL and SDA are sampled by a faster system clock through short synchronizers. START and STOP are found by watching SDA move while SCL is high. The block drives SDA only through an open-drain enable: while `sda_oe_o` is high, the line is pulled low.

In a write, the first byte after the address is a pointer that picks a register. Later bytes in the same transaction land in that register. In a read, the selected register is sent repeatedly for as long as the master acknowledges. A master NACK makes the block release the bus and ignore it until the next STOP.

The pin drivers follow the output and direction registers. The input-level register shows the pins after optional per-bit inversion.

Top module: `i2c_gpio_exp`

## Requirements
- R1: After reset, `pin_o` is 0xFF and `pin_oe_o` is 0x00 (all pins inputs). `sda_oe_o` is 0. Reading pointers 0x01, 0x02 and 0x03 returns 0xFF, 0x00 and 0xFF.
- R2: The block acknowledges an address byte only when its upper seven bits equal `{ADDR_HI, addr_sel_i}`. Bit 0 is the direction: 1 means read. For any other address, SDA stays released for the rest of the transaction.
- R3: In a write, every byte is acknowledged. The first data byte (the byte after the address) sets the pointer. Each further byte is stored in the selected register, so the last byte wins.
- R4: Direction register bit = 1 makes that pin an input (`pin_oe_o` bit 0). Bit = 0 enables the driver. `pin_o` always equals the output register (pointer 0x01). Neither output changes except by a write to its own register.
- R5: A read at pointer 0x00 returns the synchronized `pin_i` XOR the inversion register (pointer 0x02). This holds for any setting of the direction register (pointer 0x03).
- R6: Data written at pointer 0x00 or at any pointer above 0x03 is acknowledged and changes no register. A read at a pointer above 0x03 returns 0xFF.
- R7: Read data is sent MSB first. After a master ACK, the same register is sent again. After a master NACK, the block releases SDA and does not drive it again before a STOP.
- R8: The pointer keeps its value across STOPs and never increments. A read with no preceding pointer byte uses the last pointer written.
- R9: A repeated START restarts address matching from any state. This applies both to a write-then-read sequence and to a restart with a foreign address.
- R10: `sda_oe_o` never changes while SCL stays high.
- R11: A STOP returns the block to idle with SDA released, and a following START is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 3 | Low three address bits |
| pin_i | input | 8 | Pin levels |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Per-pin driver enable |

## Verification
The bench builds the block with its defaults: address upper nibble 0x4 and two synchronizer stages. With these defaults, all 128 seven-bit address codes can be swept against one select value. All eight select values can also be swept against the block's own address.

Register contents are 8-bit, so a spread of inversion, pin and direction patterns checks the input read path arithmetically. Every pointer class is reached: read-only, the three writable registers, and an unmapped value.

// File: rtl/i2c_gpio_pkg.sv
package i2c_gpio_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WR, ST_ACK, ST_TX, ST_TXACK, ST_HOLD
  } st_e;

  localparam logic [7:0] PTR_IN  = 8'h00;
  localparam logic [7:0] PTR_OUT = 8'h01;
  localparam logic [7:0] PTR_POL = 8'h02;
  localparam logic [7:0] PTR_CFG = 8'h03;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_gpio_regs.sv
module i2c_gpio_regs
  import i2c_gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [7:0]        rd_sel_i,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] pin_o,
  output logic [BYTE_W-1:0] pin_oe_o
);
  logic [BYTE_W-1:0] out_q, pol_q, cfg_q;
  logic [BYTE_W-1:0] pin_ff [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_pin_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pin_ff[g] <= '0;
      else if (g == 0) pin_ff[g] <= pin_i;
      else             pin_ff[g] <= pin_ff[(g > 0) ? g-1 : 0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        PTR_OUT: out_q <= wr_data_i;
        PTR_POL: pol_q <= wr_data_i;
        PTR_CFG: cfg_q <= wr_data_i;
        default: ;  // input register and unmapped pointers are read-only
      endcase
    end
  end

  always_comb begin
    unique case (rd_sel_i)
      PTR_IN:  rd_data_o = pin_ff[SYNC_STAGES-1] ^ pol_q;
      PTR_OUT: rd_data_o = out_q;
      PTR_POL: rd_data_o = pol_q;
      PTR_CFG: rd_data_o = cfg_q;
      default: rd_data_o = '1;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = ~cfg_q;
endmodule

// File: rtl/i2c_gpio_exp.sv
module i2c_gpio_exp
  import i2c_gpio_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'h4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [2:0]  addr_sel_i,
  input  logic [7:0]  pin_i,
  output logic [7:0]  pin_o,
  output logic [7:0]  pin_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_e  st_q, nxt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, ptr_q, rd_data;
  logic sda_oe_q, rd_mode_q, mack_q;
  logic wr_en;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign wr_en = (st_q == ST_WR) && scl_fall && (cnt_q == CNT_FULL)
                 && !start_det && !stop_det;

  i2c_gpio_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_sel_i(ptr_q), .wr_data_i(sh_q),
    .rd_sel_i(ptr_q), .pin_i, .rd_data_o(rd_data),
    .pin_o, .pin_oe_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      ptr_q     <= PTR_IN;
      sda_oe_q  <= 1'b0;
      rd_mode_q <= 1'b0;
      mack_q    <= 1'b0;
    end else if (start_det) begin
      st_q     <= ST_ADDR;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      st_q     <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_q <= '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == {ADDR_HI, addr_sel_i}) begin
                sda_oe_q  <= 1'b1;
                rd_mode_q <= sh_q[0];
                nxt_q     <= ST_CMD;
                st_q      <= ST_ACK;
              end else begin
                st_q <= ST_HOLD;
              end
            end else begin
              if (st_q == ST_CMD) ptr_q <= sh_q;
              sda_oe_q  <= 1'b1;
              rd_mode_q <= 1'b0;
              nxt_q     <= ST_WR;
              st_q      <= ST_ACK;
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          cnt_q <= '0;
          if (rd_mode_q) begin
            sh_q     <= rd_data;
            sda_oe_q <= ~rd_data[BYTE_W-1];
            st_q     <= ST_TX;
          end else begin
            sda_oe_q <= 1'b0;
            st_q     <= nxt_q;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt_q == CNT_LAST) begin
            sda_oe_q <= 1'b0;
            st_q     <= ST_TXACK;
          end else begin
            sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
            sda_oe_q <= ~sh_q[BYTE_W-2];
            cnt_q    <= cnt_q + 1'b1;
          end
        end
        ST_TXACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            cnt_q <= '0;
            if (mack_q) begin
              sh_q     <= rd_data;
              sda_oe_q <= ~rd_data[BYTE_W-1];
              st_q     <= ST_TX;
            end else begin
              st_q <= ST_HOLD;
            end
          end
        end
        default: ;  // idle or waiting for STOP
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/i2c_gpio_exp_chk.sv
module i2c_gpio_exp_chk
  import i2c_gpio_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input st_e        st_q,
  input logic       stop_det,
  input logic       wr_en,
  input logic [7:0] wr_sel,
  input logic [7:0] pin_o,
  input logic [7:0] pin_oe_o
);
  // R10
  sda_hold_scl_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(scl_i) && scl_i) |-> $stable(sda_oe_o));

  // R11
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  // R2
  quiet_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE || st_q == ST_HOLD) |-> !sda_oe_o);

  // R4
  pin_o_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_o) |-> $past(wr_en && wr_sel == PTR_OUT));

  // R4
  pin_oe_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_oe_o) |-> $past(wr_en && wr_sel == PTR_CFG));
endmodule

bind i2c_gpio_exp i2c_gpio_exp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .st_q(st_q), .stop_det(stop_det), .wr_en(wr_en), .wr_sel(ptr_q),
  .pin_o(pin_o), .pin_oe_o(pin_oe_o)
);

// File: tb/i2c_gpio_exp_tb.sv
module i2c_gpio_exp_tb;
  localparam int Q = 8;  // system cycles per SCL quarter step
  localparam logic [3:0] HI = 4'h4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m_low = 1'b0;
  logic [2:0] addr_sel_i = 3'd5;
  logic [7:0] pin_i = 8'h00;
  logic sda_oe_o, sda_line;
  logic [7:0] pin_o, pin_oe_o;
  int n_chk = 0, n_err = 0, viol = 0;
  logic scl_p = 1'b1, oe_p = 1'b0;

  always #2 clk_i = ~clk_i;
  assign sda_line = ~(sda_oe_o | sda_m_low);

  i2c_gpio_exp u_dut (
    .clk_i, .rst_ni, .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o,
    .addr_sel_i, .pin_i, .pin_o, .pin_oe_o
  );

  // R10 monitor: SDA enable must hold while SCL stays high
  always @(negedge clk_i) begin
    if (rst_ni && scl_p && scl_m && (sda_oe_o != oe_p)) viol++;
    scl_p = scl_m;
    oe_p  = sda_oe_o;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic w(); repeat (Q) @(negedge clk_i); endtask

  task automatic i2c_start();
    sda_m_low = 1'b0; w(); scl_m = 1'b1; w();
    sda_m_low = 1'b1; w(); scl_m = 1'b0; w();
  endtask

  task automatic i2c_stop();
    sda_m_low = 1'b1; w(); scl_m = 1'b1; w();
    sda_m_low = 1'b0; w();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m_low = ~b[i]; w(); scl_m = 1'b1; w(); scl_m = 1'b0; w();
    end
    sda_m_low = 1'b0; w(); scl_m = 1'b1; w();
    ack = ~sda_line;
    scl_m = 1'b0; w();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      w(); scl_m = 1'b1; w(); b[i] = sda_line; scl_m = 1'b0;
    end
    w(); sda_m_low = give_ack; w(); scl_m = 1'b1; w(); scl_m = 1'b0; w();
    sda_m_low = 1'b0;
  endtask

  function automatic logic [7:0] own(input logic [2:0] s);
    return {HI, s, 1'b0};
  endfunction

  task automatic wr_reg(input logic [7:0] ptr, input logic [7:0] d, input string tag);
    logic a;
    i2c_start();
    send_byte(own(addr_sel_i), a); chk({tag, " addr ack"}, a, 1);
    send_byte(ptr, a);             chk({tag, " ptr ack"}, a, 1);
    send_byte(d, a);               chk({tag, " data ack"}, a, 1);
    i2c_stop();
  endtask

  // pointer write then repeated START into a read (R9)
  task automatic rd_reg(input logic [7:0] ptr, output logic [7:0] d);
    logic a;
    i2c_start();
    send_byte(own(addr_sel_i), a);
    send_byte(ptr, a);
    i2c_start();
    send_byte(own(addr_sel_i) | 8'h01, a); chk("R9 restart read ack", a, 1);
    recv_byte(1'b0, d);
    i2c_stop();
  endtask

  initial begin
    repeat (400000) @(posedge clk_i);
    n_err++;
    $display("FAIL R11 watchdog got=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d, d2, d3;
    repeat (5) @(negedge clk_i);
    chk("R1 sda_oe reset", sda_oe_o, 0);
    chk("R1 pin_o reset", pin_o, 8'hFF);
    chk("R1 pin_oe reset", pin_oe_o, 8'h00);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    rd_reg(8'h01, d); chk("R1 out reg reset", d, 8'hFF);
    rd_reg(8'h02, d); chk("R1 pol reg reset", d, 8'h00);
    rd_reg(8'h03, d); chk("R1 cfg reg reset", d, 8'hFF);

    // R2: full address sweep
    for (int k = 0; k < 128; k++) begin
      i2c_start();
      send_byte({k[6:0], 1'b0}, a);
      chk("R2 address match", a, (k[6:0] == {HI, addr_sel_i}) ? 1 : 0);
      if (k == 0) begin
        send_byte(8'h01, a); chk("R2 foreign stays released", a, 0);
      end
      i2c_stop();
    end
    // R2: every select value
    for (int s = 0; s < 8; s++) begin
      addr_sel_i = s[2:0];
      i2c_start(); send_byte(own(s[2:0]), a); i2c_stop();
      chk("R2 select value ack", a, 1);
    end
    addr_sel_i = 3'd5;

    // R3 / R4
    wr_reg(8'h01, 8'hA5, "R3");
    chk("R3 out reg write", pin_o, 8'hA5);
    wr_reg(8'h03, 8'h0F, "R4");
    chk("R4 cfg to pin_oe", pin_oe_o, 8'hF0);
    chk("R4 pin_o unchanged", pin_o, 8'hA5);
    i2c_start();
    send_byte(own(addr_sel_i), a);
    send_byte(8'h01, a);
    send_byte(8'h11, a); chk("R3 burst byte1 ack", a, 1);
    send_byte(8'h22, a); chk("R3 burst byte2 ack", a, 1);
    i2c_stop();
    chk("R3 last byte wins", pin_o, 8'h22);

    // R5: input read sweep across inversion, pin and direction patterns
    for (int k = 0; k < 12; k++) begin
      logic [7:0] pol, pv;
      pol = 8'(k * 17) ^ 8'h5A;
      pv  = 8'(k * 29 + 3);
      pin_i = pv;
      wr_reg(8'h02, pol, "R5");
      wr_reg(8'h03, 8'(k * 51), "R5");
      rd_reg(8'h00, d);
      chk("R5 input read", d, pv ^ pol);
    end

    // R6: writes to input register and unmapped pointer
    wr_reg(8'h03, 8'h0F, "R6");
    wr_reg(8'h02, 8'h00, "R6");
    pin_i = 8'h3C;
    wr_reg(8'h00, 8'hC3, "R6");
    rd_reg(8'h00, d); chk("R6 input reg ignores write", d, 8'h3C);
    wr_reg(8'h07, 8'h00, "R6");
    chk("R6 unmapped pin_o", pin_o, 8'h22);
    chk("R6 unmapped pin_oe", pin_oe_o, 8'hF0);
    rd_reg(8'h07, d); chk("R6 unmapped read", d, 8'hFF);
    rd_reg(8'h02, d); chk("R6 pol untouched", d, 8'h00);

    // R8: pointer persists, no increment; R7: ACK continues, NACK releases
    i2c_start(); send_byte(own(addr_sel_i), a); send_byte(8'h01, a); i2c_stop();
    i2c_start();
    send_byte(own(addr_sel_i) | 8'h01, a);
    recv_byte(1'b1, d); recv_byte(1'b1, d2); recv_byte(1'b0, d3);
    chk("R8 pointer kept", d, 8'h22);
    chk("R7 repeat after ack", d2, 8'h22);
    chk("R7 repeat after ack 2", d3, 8'h22);
    recv_byte(1'b0, d); chk("R7 released after nack", d, 8'hFF);
    i2c_stop();
    chk("R11 sda released after stop", sda_oe_o, 0);

    // R9: restart with foreign address, then own address
    i2c_start(); send_byte(own(addr_sel_i), a); send_byte(8'h03, a);
    i2c_start(); send_byte(8'h90, a); chk("R9 foreign restart nack", a, 0);
    i2c_start(); send_byte(own(addr_sel_i) | 8'h01, a);
    chk("R9 own restart ack", a, 1);
    recv_byte(1'b0, d); chk("R9 read after restarts", d, 8'h0F);
    i2c_stop();

    // R11: idle and new START served
    i2c_start(); send_byte(own(addr_sel_i), a); i2c_stop();
    chk("R11 new start ack", a, 1);
    chk("R10 sda change with scl high", viol, 0);
    summary();
    $finish;
  end
endmodule